// File: doc/BRIEF.md
# Cache Tag Store with Hit Compare

This block keeps the tag directory of a direct-mapped cache. It has one entry per cache line. Each entry stores a tag, a valid bit and a dirty bit. Every clock edge performs one lookup. The set index and the tag of the current access are sampled at the edge. On the next cycle the block reports three things: whether the line hit, whether the entry is valid, and whether the line is dirty. With the dirty flag the cache controller can decide whether a victim line must be written back before refill.

The same edge can also carry an update. While the write strobe is high, the presented tag, valid-in bit and dirty-in bit replace the entry at the index. A flush input invalidates every entry at once, within a single edge. The stored tag read by the last lookup can be driven onto a tag bus under an output enable. With the enable low the bus is left undriven (high impedance).

With the default parameters the store holds 1K entries. Setting `IDX_W` to 14 gives the full 16K-entry directory with a 12-bit tag.

Top module: `tag_store_cmp`

## Requirements
- R1: A lookup of `idx_i`/`tag_i` sampled at a rising edge is reported on `match_o`, `valid_o` and `dirty_o` after that same edge, with a latency of one cycle, and the outputs hold until the next edge.
- R2: `match_o` is 1 exactly when the looked-up entry is valid and its stored tag equals the presented tag bit for bit.
- R3: An entry whose valid bit is 0 never produces `match_o` = 1, whatever tag it holds.
- R4: With `we_i` = 1 and `clr_i` = 0 at a rising edge, the entry at `idx_i` takes `tag_i`, `vin_i` and `din_i`. A later lookup of that index returns them.
- R5: When a lookup and a write address the same index at the same edge, the outputs reflect the contents held before that write.
- R6: With `clr_i` = 1 at a rising edge, every entry becomes invalid. Any lookup at a later edge reports `valid_o` = 0 and `match_o` = 0 until the entry is written again.
- R7: A write presented in the same cycle as `clr_i` = 1 is discarded, so the addressed entry is invalid afterwards.
- R8: `dirty_o` gives the stored dirty bit of a valid entry. It is 0 for an invalid entry.
- R9: With `oe_i` = 1, `tag_o` drives the stored tag read by the last lookup. With `oe_i` = 0, `tag_o` is high impedance.
- R10: While `rst_n` is low, all entries are made invalid and `match_o`, `valid_o` and `dirty_o` are 0.

Ports table: in the Width column, I is `IDX_W` and T is `TAG_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; lookups and writes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_i | input | I | Set index of the access |
| tag_i | input | T | Tag to compare and, on a write, to store |
| vin_i | input | 1 | Valid bit to store on a write |
| din_i | input | 1 | Dirty bit to store on a write |
| we_i | input | 1 | Write strobe for the indexed entry |
| clr_i | input | 1 | Flush: invalidates all entries, overrides a write |
| oe_i | input | 1 | Drive enable for `tag_o` |
| match_o | output | 1 | Hit: entry valid and tags equal |
| dirty_o | output | 1 | Dirty bit of a valid looked-up entry |
| valid_o | output | 1 | Valid bit of the looked-up entry |
| tag_o | output | T | Stored tag of the last lookup, or high impedance |

## Verification
The bench goes after the following corners. A write and a lookup of the same index at the same edge must still report the old contents; a design that forwarded the new data would show a hit one cycle early. A flush issued together with a write must leave that entry invalid; a design that let the write win would report a hit on a line that should be gone. An entry marked invalid that still holds a matching tag must miss and report clean; a design that compared tags alone, or exported the raw dirty bit, would hit or ask for a useless write-back. A long run of mixed writes, flushes and lookups over a few indices is compared against a shadow directory, to catch a wrong latency or a mix-up between entries.

// File: rtl/tagc_pkg.sv
package tagc_pkg;

    // Result of one lookup, as handed from the compare stage to the top.
    typedef struct packed {
        logic hit;
        logic vld;
        logic dty;
    } look_res_t;

endpackage

// File: rtl/tagc_valid_bank.sv
module tagc_valid_bank #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             vin_i,
    output logic             rd_vld_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] vld_q;

    // Valid bits live in flops so a flush can reset them all in one edge.
    // The read samples the value held before this edge's update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            rd_vld_o <= 1'b0;
        end else begin
            rd_vld_o <= vld_q[idx_i];
            if (clr_i) begin
                vld_q <= '0;
            end else if (we_i) begin
                vld_q[idx_i] <= vin_i;
            end
        end
    end

    p_flash_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld_q == '0));

    p_write_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> (vld_q[$past(idx_i)] == $past(vin_i)));

endmodule

// File: rtl/tagc_array.sv
module tagc_array #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             din_i,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic             rd_dty_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int WORD  = TAG_W + 1;

    logic [WORD-1:0] mem [DEPTH];

    // Read-before-write single-port store, no reset (inferred RAM).
    always_ff @(posedge clk) begin
        {rd_dty_o, rd_tag_o} <= mem[idx_i];
        if (we_i) begin
            mem[idx_i] <= {din_i, tag_i};
        end
    end

endmodule

// File: rtl/tagc_compare.sv
module tagc_compare
    import tagc_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    input  logic             rd_vld_i,
    input  logic             rd_dty_i,
    output look_res_t        res_o
);
    logic [TAG_W-1:0] cmp_q;

    // The presented tag is registered alongside the storage read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= tag_i;
        end
    end

    always_comb begin
        res_o.vld = rd_vld_i;
        res_o.hit = rd_vld_i & (rd_tag_i == cmp_q);
        res_o.dty = rd_vld_i & rd_dty_i;
    end

endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
    import tagc_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             vin_i,
    input  logic             din_i,
    input  logic             we_i,
    input  logic             clr_i,
    input  logic             oe_i,
    output logic             match_o,
    output logic             dirty_o,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o
);
    logic             arr_we;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_dty;
    logic             rd_vld;
    look_res_t        res;

    // A flush discards a concurrent write.
    assign arr_we = we_i & ~clr_i;

    tagc_valid_bank #(.IDX_W(IDX_W)) u_vld (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_i),
        .we_i     (we_i),
        .idx_i    (idx_i),
        .vin_i    (vin_i),
        .rd_vld_o (rd_vld)
    );

    tagc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
        .clk      (clk),
        .we_i     (arr_we),
        .idx_i    (idx_i),
        .tag_i    (tag_i),
        .din_i    (din_i),
        .rd_tag_o (rd_tag),
        .rd_dty_o (rd_dty)
    );

    tagc_compare #(.TAG_W(TAG_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tag_i    (tag_i),
        .rd_tag_i (rd_tag),
        .rd_vld_i (rd_vld),
        .rd_dty_i (rd_dty),
        .res_o    (res)
    );

    assign match_o = res.hit;
    assign valid_o = res.vld;
    assign dirty_o = res.dty;
    assign tag_o   = oe_i ? rd_tag : {TAG_W{1'bz}};

    p_invalid_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> valid_o);

    p_dirty_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_o |-> valid_o);

    p_clear_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i, 2) |-> (!valid_o && !match_o));

endmodule

// File: tb/tb_tag_store_cmp.sv
module tb_tag_store_cmp;
    localparam int IDX_W  = 10;
    localparam int TAG_W  = 12;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] idx_i = '0;
    logic [TAG_W-1:0] tag_i = '0;
    logic             vin_i = 1'b0;
    logic             din_i = 1'b0;
    logic             we_i = 1'b0;
    logic             clr_i = 1'b0;
    logic             oe_i = 1'b0;
    logic             match_o, dirty_o, valid_o;
    logic [TAG_W-1:0] tag_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Shadow directory
    bit             sh_v [DEPTH];
    bit             sh_d [DEPTH];
    bit             sh_w [DEPTH];
    bit [TAG_W-1:0] sh_t [DEPTH];

    always #(PERIOD/2) clk = ~clk;

    tag_store_cmp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .tag_i(tag_i),
        .vin_i(vin_i), .din_i(din_i), .we_i(we_i), .clr_i(clr_i),
        .oe_i(oe_i), .match_o(match_o), .dirty_o(dirty_o),
        .valid_o(valid_o), .tag_o(tag_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: lookup of idx/tag plus optional write or flush.
    task automatic op(int idx, int tag, bit we, bit vin, bit din, bit clr, bit oe, string req);
        bit exp_v, exp_m, exp_d, exp_w;
        bit [TAG_W-1:0] exp_t;
        exp_v = sh_v[idx];
        exp_m = sh_v[idx] && (sh_t[idx] == TAG_W'(tag));
        exp_d = sh_v[idx] && sh_d[idx];
        exp_w = sh_w[idx];
        exp_t = sh_t[idx];
        @(negedge clk);
        idx_i = IDX_W'(idx); tag_i = TAG_W'(tag);
        we_i = we; vin_i = vin; din_i = din; clr_i = clr; oe_i = oe;
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < DEPTH; k++) sh_v[k] = 1'b0;
        end else if (we) begin
            sh_v[idx] = vin; sh_d[idx] = din; sh_t[idx] = TAG_W'(tag); sh_w[idx] = 1'b1;
        end
        #1;
        chk(valid_o === exp_v, req, "valid_o", int'(valid_o), int'(exp_v));
        chk(match_o === exp_m, req, "match_o", int'(match_o), int'(exp_m));
        chk(dirty_o === exp_d, req, "dirty_o", int'(dirty_o), int'(exp_d));
        if (oe && exp_w)
            chk(tag_o === exp_t, "R9", "tag_o", int'(tag_o), int'(exp_t));
        @(negedge clk);
        we_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(valid_o === 1'b0, "R10", "valid_o in reset", int'(valid_o), 0);
        chk(match_o === 1'b0, "R10", "match_o in reset", int'(match_o), 0);
        chk(dirty_o === 1'b0, "R10", "dirty_o in reset", int'(dirty_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        op(3, 0, 0, 0, 0, 0, 1, "R10");
    endtask

    task automatic t_write_hit;
        op(5, 'hABC, 1, 1, 0, 0, 1, "R5");   // old contents: invalid
        op(5, 'hABC, 0, 0, 0, 0, 1, "R4");   // R1/R2: hit one cycle later
        op(5, 'hABD, 0, 0, 0, 0, 1, "R2");   // one bit differs: miss
        op(5, 'h2BC, 0, 0, 0, 0, 1, "R2");
    endtask

    task automatic t_dirty;
        op(7, 'h123, 1, 1, 1, 0, 1, "R4");
        op(7, 'h123, 0, 0, 0, 0, 1, "R8");   // dirty hit
        op(7, 'h123, 1, 0, 1, 0, 1, "R8");   // mark invalid, tag kept
        op(7, 'h123, 0, 0, 0, 0, 1, "R3");   // same tag, invalid: miss, clean
    endtask

    task automatic t_rbw;
        op(5, 'h555, 1, 1, 1, 0, 1, "R5");   // sees old tag ABC: no hit
        op(5, 'h555, 0, 0, 0, 0, 1, "R1");
    endtask

    task automatic t_clear;
        op(20, 'h0F0, 1, 1, 0, 0, 1, "R4");
        op(21, 'h0F1, 1, 1, 1, 0, 1, "R4");
        op(20, 'h0F0, 0, 0, 0, 1, 1, "R6");  // lookup at flush edge still hits
        op(20, 'h0F0, 0, 0, 0, 0, 1, "R6");
        op(21, 'h0F1, 0, 0, 0, 0, 1, "R6");
        op(5,  'h555, 0, 0, 0, 0, 1, "R6");
        op(9,  'h099, 1, 1, 1, 1, 1, "R7");  // write dropped by flush
        op(9,  'h099, 0, 0, 0, 0, 1, "R7");
    endtask

    task automatic t_oe;
        op(30, 'hA5A, 1, 1, 0, 0, 1, "R4");
        op(30, 'hA5A, 0, 0, 0, 0, 1, "R9");  // drives stored tag
        op(30, 'hA5A, 0, 0, 0, 0, 0, "R9");
        // Undriven bus reads as z in four-state and as 0 in two-state simulators.
        chk((tag_o === {TAG_W{1'bz}}) || (tag_o === '0), "R9", "tag_o undriven",
            int'(tag_o), 0);
    endtask

    task automatic t_random;
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            op(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
               r < 45, r < 35, r[0], r > 96, 1'b1, "R2");
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(13));
        for (int k = 0; k < DEPTH; k++) begin
            sh_v[k] = 1'b0; sh_d[k] = 1'b0; sh_w[k] = 1'b0; sh_t[k] = '0;
        end
        t_reset();
        t_write_hit();
        t_dirty();
        t_rbw();
        t_clear();
        t_oe();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule